// File: doc/BRIEF.md
# Instruction Prefetch Byte Queue

This block sits between a bus fetch engine and an instruction consumer and holds up to six instruction bytes in arrival order. While the consumer is busy with work that does not use the bus, the queue keeps asking for more code as long as it has room. An even fetch address asks for a 16-bit word, which fills two bytes. An odd fetch address asks for a single byte, which realigns the stream to a word boundary. The queue keeps its own fetch pointer and advances it by the number of bytes it actually accepts.

On the consumer side the oldest bytes are always visible in parallel on a flat head vector, together with the count of valid bytes. The consumer removes between one and six bytes in a single cycle by naming the count. A request for more bytes than are held, or for zero bytes, is refused and flagged in the same cycle. When the program flow changes, a flush empties the queue and reloads the fetch pointer with the new address. A fill that lands in the flush cycle is dropped.

Top module: `prefetch_queue`

## Requirements
- R1: While reset is asserted on a clock edge, the queue becomes empty (occupancy 0) and the fetch address becomes RESET_ADDR (default 0). With take_valid low, take_err is 0.
- R2: Byte k of head_bytes (bits 8k+7 down to 8k) is the k-th oldest byte held, for every k below the occupancy.
- R3: The occupancy never exceeds DEPTH (6).
- R4: With fetch_addr bit 0 clear, fetch_req is high exactly when at least 2 bytes are free, and fetch_byte is 0. With bit 0 set, fetch_req is high exactly when at least 1 byte is free, and fetch_byte is 1.
- R5: On an accepted word fill, fill_data[7:0] is queued before fill_data[15:8]. On an accepted single-byte fill, fill_data[15:8] is queued.
- R6: A removal of n bytes, with 1 <= n <= occupancy, drops the n oldest bytes and moves the rest to the head in order.
- R7: When take_valid is high and take_cnt is 0 or greater than the occupancy, take_err is high in that same cycle and no bytes are removed.
- R8: A fill and a removal in the same cycle both take effect, and the next occupancy is the old occupancy minus the bytes removed plus the bytes filled.
- R9: A flush makes the occupancy 0 and the fetch address equal to flush_addr on the next cycle. A fill or removal in the flush cycle has no effect.
- R10: An accepted fill advances fetch_addr by 1 for a byte fill or by 2 for a word fill, modulo 2^ADDR_W.
- R11: fill_valid while fetch_req is low has no effect on the occupancy, the held bytes or fetch_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Empty the queue and reload the fetch address |
| flush_addr | input | ADDR_W | New fetch address used on flush |
| fetch_req | output | 1 | Queue has room for the pending fetch |
| fetch_byte | output | 1 | Pending fetch is a single byte (odd address) |
| fetch_addr | output | ADDR_W | Address of the next byte to fetch |
| fill_valid | input | 1 | Fetched data is present on fill_data |
| fill_data | input | 16 | Fetched word, low byte at the even address |
| occupancy | output | CNT_W | Number of valid bytes held |
| head_bytes | output | DEPTH*8 | Held bytes, oldest in the low byte |
| take_valid | input | 1 | Consumer removes bytes this cycle |
| take_cnt | input | CNT_W | Number of bytes to remove |
| take_err | output | 1 | Removal refused (zero or above occupancy) |

## Verification
A fill and a removal can land in the same cycle. So can a flush and a fill, and a flush and a removal. The random stimulus raises fill_valid and take_valid independently, with flushes mixed in. Directed steps force a word fill together with a one-byte removal, and a flush together with a fill. A bench reference queue judges each case: it applies the removal before appending the filled bytes, and it lets the flush override both. After every edge, the bench compares the occupancy, every valid head byte and the fetch address with that reference.

// File: rtl/pq_pkg.sv
// Shared constants and types for the prefetch byte queue.
package pq_pkg;
    localparam int BYTE_W = 8;
    localparam int FILL_W = 16;
    typedef logic [BYTE_W-1:0] qbyte_t;
endpackage

// File: rtl/pq_fetch_ctrl.sv
// Fetch control: decides whether a fetch may be requested, its size,
// and keeps the fetch address. Assumes fill data only counts while
// fetch_req is high and no flush is present.
module pq_fetch_ctrl #(
    parameter int DEPTH      = 6,
    parameter int ADDR_W     = 20,
    parameter int CNT_W      = 3,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [ADDR_W-1:0] flush_addr,
    input  logic              fill_valid,
    input  logic [CNT_W-1:0]  occ,
    output logic              fetch_req,
    output logic              fetch_byte,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [1:0]        fill_cnt
);
    logic [ADDR_W-1:0] ptr_q;
    logic [CNT_W-1:0]  free;

    // Free byte slots left in the queue.
    assign free       = CNT_W'(DEPTH) - occ;
    // Odd address means a single byte fetch to realign.
    assign fetch_byte = ptr_q[0];
    // Request only when the whole fetch would fit.
    assign fetch_req  = fetch_byte ? (free >= CNT_W'(1)) : (free >= CNT_W'(2));
    // Bytes taken in from the bus this cycle.
    assign fill_cnt   = (fill_valid && fetch_req && !flush)
                        ? (fetch_byte ? 2'd1 : 2'd2) : 2'd0;
    assign fetch_addr = ptr_q;

    // Fetch pointer: reload on flush, else step by accepted bytes.
    always_ff @(posedge clk) begin
        if (!rst_n)     ptr_q <= RESET_ADDR;
        else if (flush) ptr_q <= flush_addr;
        else            ptr_q <= ptr_q + ADDR_W'(fill_cnt);
    end
endmodule

// File: rtl/pq_take_check.sv
// Removal check: accepts a byte removal only if 1 <= count <= occupancy,
// otherwise raises the error strobe and removes nothing.
module pq_take_check #(
    parameter int CNT_W = 3
) (
    input  logic             take_valid,
    input  logic [CNT_W-1:0] take_cnt,
    input  logic [CNT_W-1:0] occ,
    output logic             take_err,
    output logic [CNT_W-1:0] take_n
);
    logic bad_cnt;

    // Zero or more than held is an illegal removal.
    assign bad_cnt  = (take_cnt == '0) || (take_cnt > occ);
    // Error strobe in the request cycle.
    assign take_err = take_valid && bad_cnt;
    // Bytes actually removed.
    assign take_n   = (take_valid && !bad_cnt) ? take_cnt : '0;
endmodule

// File: rtl/pq_store.sv
// Byte store: slot 0 always holds the oldest byte. A removal shifts the
// survivors down and up to two fill bytes land right behind them.
// Assumes take_n <= occ and that fill_cnt fits in the free space.
module pq_store
    import pq_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int CNT_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [CNT_W-1:0]        take_n,
    input  logic [1:0]              fill_cnt,
    input  logic                    fill_odd,
    input  logic [FILL_W-1:0]       fill_data,
    output logic [CNT_W-1:0]        occ,
    output logic [DEPTH*BYTE_W-1:0] head
);
    qbyte_t           slot_q [DEPTH];
    qbyte_t           slot_d [DEPTH];
    qbyte_t           lane0;
    qbyte_t           lane1;
    logic [CNT_W-1:0] rem;

    // First queued fill byte: high lane for a single odd byte.
    assign lane0 = fill_odd ? fill_data[FILL_W-1:BYTE_W] : fill_data[BYTE_W-1:0];
    // Second queued fill byte of a word.
    assign lane1 = fill_data[FILL_W-1:BYTE_W];
    // Bytes surviving the removal.
    assign rem   = occ - take_n;

    // Next slot contents: shifted survivors then fill bytes.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (i < int'(rem))
                slot_d[i] = slot_q[(i + int'(take_n)) % DEPTH];
            else if (i == int'(rem))
                slot_d[i] = lane0;
            else if (i == int'(rem) + 1)
                slot_d[i] = lane1;
            else
                slot_d[i] = '0;
        end
    end

    // Slot registers; contents are left alone on flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else if (!flush) begin
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= slot_d[i];
        end
    end

    // Occupancy: cleared by flush, else survivors plus fill.
    always_ff @(posedge clk) begin
        if (!rst_n)     occ <= '0;
        else if (flush) occ <= '0;
        else            occ <= rem + CNT_W'(fill_cnt);
    end

    // Flatten slots onto the head vector, oldest in the low byte.
    for (genvar g = 0; g < DEPTH; g++) begin : g_head
        assign head[g*BYTE_W +: BYTE_W] = slot_q[g];
    end
endmodule

// File: rtl/prefetch_queue.sv
// Prefetch byte queue top: word-wide fill from a fetch engine, a
// variable byte-count removal by the consumer, and flush on a change of
// program flow. Assumes fill data is valid only in response to fetch_req.
module prefetch_queue
    import pq_pkg::*;
#(
    parameter int DEPTH  = 6,
    parameter int ADDR_W = 20,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    flush,
    input  logic [ADDR_W-1:0]       flush_addr,
    output logic                    fetch_req,
    output logic                    fetch_byte,
    output logic [ADDR_W-1:0]       fetch_addr,
    input  logic                    fill_valid,
    input  logic [FILL_W-1:0]       fill_data,
    output logic [CNT_W-1:0]        occupancy,
    output logic [DEPTH*BYTE_W-1:0] head_bytes,
    input  logic                    take_valid,
    input  logic [CNT_W-1:0]        take_cnt,
    output logic                    take_err
);
    logic [1:0]       fill_cnt;
    logic [CNT_W-1:0] take_n;

    pq_fetch_ctrl #(
        .DEPTH(DEPTH), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .RESET_ADDR(RESET_ADDR)
    ) fetch_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
        .fill_valid(fill_valid), .occ(occupancy), .fetch_req(fetch_req),
        .fetch_byte(fetch_byte), .fetch_addr(fetch_addr), .fill_cnt(fill_cnt)
    );

    pq_take_check #(.CNT_W(CNT_W)) take_i (
        .take_valid(take_valid), .take_cnt(take_cnt), .occ(occupancy),
        .take_err(take_err), .take_n(take_n)
    );

    pq_store #(.DEPTH(DEPTH), .CNT_W(CNT_W)) store_i (
        .clk(clk), .rst_n(rst_n), .flush(flush), .take_n(take_n),
        .fill_cnt(fill_cnt), .fill_odd(fetch_byte), .fill_data(fill_data),
        .occ(occupancy), .head(head_bytes)
    );
endmodule

// File: rtl/pq_checker.sv
// Property checker for prefetch_queue, attached by bind.
module pq_checker #(
    parameter int DEPTH  = 6,
    parameter int ADDR_W = 20,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                flush,
    input logic [ADDR_W-1:0]   flush_addr,
    input logic                fetch_req,
    input logic                fetch_byte,
    input logic [ADDR_W-1:0]   fetch_addr,
    input logic                fill_valid,
    input logic [15:0]         fill_data,
    input logic [CNT_W-1:0]    occupancy,
    input logic [DEPTH*8-1:0]  head_bytes,
    input logic                take_valid,
    input logic [CNT_W-1:0]    take_cnt,
    input logic                take_err
);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occupancy) <= DEPTH);

    a_r4_word_fits: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_req && !fetch_byte) |-> int'(occupancy) <= DEPTH - 2);

    a_r4_full_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(occupancy) == DEPTH) |-> !fetch_req);

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (occupancy == '0) && (fetch_addr == $past(flush_addr)));

    a_r10_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && fill_valid && fetch_req) |=>
        fetch_addr == $past(fetch_addr) + ($past(fetch_byte) ? ADDR_W'(1) : ADDR_W'(2)));

    a_r11_no_fill_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && !(fill_valid && fetch_req)) |=> $stable(fetch_addr));

    a_r7_refused_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && take_err && !(fill_valid && fetch_req)) |=> $stable(occupancy));

    a_r8_count_delta: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && take_valid && !take_err && fill_valid && fetch_req) |=>
        int'(occupancy) == int'($past(occupancy)) - int'($past(take_cnt))
                           + ($past(fetch_byte) ? 1 : 2));

    a_r2_head_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && take_valid && (take_cnt == CNT_W'(1)) && (int'(occupancy) >= 2)) |=>
        head_bytes[7:0] == $past(head_bytes[15:8]));
endmodule

bind prefetch_queue pq_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/prefetch_queue_tb_top.sv
`timescale 1ns/1ps
module prefetch_queue_tb_top;
    localparam int DEPTH  = 6;
    localparam int ADDR_W = 20;
    localparam int CNT_W  = 3;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                flush;
    logic [ADDR_W-1:0]   flush_addr;
    logic                fetch_req;
    logic                fetch_byte;
    logic [ADDR_W-1:0]   fetch_addr;
    logic                fill_valid;
    logic [15:0]         fill_data;
    logic [CNT_W-1:0]    occupancy;
    logic [DEPTH*8-1:0]  head_bytes;
    logic                take_valid;
    logic [CNT_W-1:0]    take_cnt;
    logic                take_err;

    always #2.5 clk = ~clk;

    prefetch_queue #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dut_i (.*);

    // Reference queue
    logic [7:0]        mq [DEPTH];
    int                mcnt;
    logic [ADDR_W-1:0] mptr;
    int                n_chk = 0;
    int                n_bad = 0;
    bit                done  = 0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic bit m_req();
        int free = DEPTH - mcnt;
        return mptr[0] ? (free >= 1) : (free >= 2);
    endfunction

    // One cycle: drive, check combinational outputs, advance model, check state.
    task automatic step(input bit fl, input logic [ADDR_W-1:0] fa, input bit fv,
                        input logic [15:0] fd, input bit tv, input int tc,
                        input string tag);
        bit er, eb, eerr;
        int nb, tk, rem;
        logic [DEPTH*8-1:0] ev, mk;
        flush = fl; flush_addr = fa; fill_valid = fv; fill_data = fd;
        take_valid = tv; take_cnt = CNT_W'(tc);
        #1;
        er   = m_req();
        eb   = mptr[0];
        eerr = tv && (tc == 0 || tc > mcnt);
        chk(fetch_req == er, "R4", "fetch_req", 64'(fetch_req), 64'(er));
        if (er) chk(fetch_byte == eb, "R4", "fetch_byte", 64'(fetch_byte), 64'(eb));
        chk(take_err == eerr, "R7", "take_err", 64'(take_err), 64'(eerr));
        if (fl) begin
            mcnt = 0;
            mptr = fa;
        end else begin
            nb  = (fv && er) ? (eb ? 1 : 2) : 0;
            tk  = (tv && !eerr) ? tc : 0;
            rem = mcnt - tk;
            for (int k = 0; k < rem; k++) mq[k] = mq[k + tk];
            if (nb == 1) mq[rem] = fd[15:8];
            if (nb == 2) begin
                mq[rem]     = fd[7:0];
                mq[rem + 1] = fd[15:8];
            end
            mcnt = rem + nb;
            mptr = mptr + ADDR_W'(nb);
        end
        @(posedge clk);
        #1;
        chk(int'(occupancy) == mcnt, tag, "occupancy", 64'(occupancy), 64'(mcnt));
        chk(int'(occupancy) <= DEPTH, "R3", "occupancy bound", 64'(occupancy), 64'(DEPTH));
        chk(fetch_addr == mptr, (tag == "R8") ? "R10" : tag, "fetch_addr",
            64'(fetch_addr), 64'(mptr));
        ev = '0; mk = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (k < mcnt) begin
                ev[k*8 +: 8] = mq[k];
                mk[k*8 +: 8] = 8'hFF;
            end
        end
        chk((head_bytes & mk) == ev, "R2", "head_bytes", 64'(head_bytes & mk), 64'(ev));
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5eed_0042);
        rst_n = 1'b0; flush = 0; flush_addr = '0; fill_valid = 0;
        fill_data = '0; take_valid = 0; take_cnt = '0;
        mcnt = 0; mptr = '0;
        for (int k = 0; k < DEPTH; k++) mq[k] = '0;
        @(posedge clk); @(posedge clk); #1;
        chk(occupancy == '0, "R1", "reset occupancy", 64'(occupancy), 64'd0);
        chk(fetch_addr == '0, "R1", "reset fetch_addr", 64'(fetch_addr), 64'd0);
        chk(take_err == 1'b0, "R1", "reset take_err", 64'(take_err), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Directed corner cases
        step(0, '0, 1, 16'hB1A0, 0, 0, "R5");       // word fill: A0 then B1
        step(0, '0, 1, 16'hD3C2, 1, 1, "R8");       // fill and take 1 together -> 3
        step(0, '0, 1, 16'hF5E4, 0, 0, "R5");       // -> 5, one slot free
        step(0, '0, 1, 16'h9999, 0, 0, "R11");      // no request at even addr: ignored
        step(0, '0, 0, 16'h0000, 1, 6, "R7");       // take 6 of 5 refused
        step(0, '0, 0, 16'h0000, 1, 5, "R6");       // take all 5
        step(0, '0, 1, 16'h2211, 0, 0, "R5");
        step(0, '0, 1, 16'h4433, 0, 0, "R5");
        step(0, '0, 1, 16'h6655, 0, 0, "R5");       // full, 6 bytes
        step(0, '0, 0, 16'h0000, 1, 6, "R6");       // take 6 at once
        step(1, 20'h00013, 1, 16'h8877, 1, 1, "R9"); // flush with fill: fill dropped
        step(0, '0, 1, 16'h5A77, 0, 0, "R5");       // odd addr: byte 5A
        step(0, '0, 0, 16'h0000, 1, 0, "R7");       // take 0 refused
        step(0, '0, 1, 16'hCDAB, 1, 1, "R8");

        // Constrained random
        for (int n = 0; n < 4000; n++) begin
            bit fl, fv, tv;
            int tc;
            logic [ADDR_W-1:0] fa;
            fl = ($urandom_range(0, 99) < 3);
            fa = ADDR_W'($urandom);
            fv = m_req() ? ($urandom_range(0, 99) < 70) : ($urandom_range(0, 99) < 10);
            tv = ($urandom_range(0, 99) < 45);
            tc = ($urandom_range(0, 9) == 0) ? $urandom_range(0, 7)
                                             : $urandom_range(1, (mcnt > 0) ? mcnt : 1);
            step(fl, fa, fv, 16'($urandom), tv, tc, "R8");
        end

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule